// File: doc/BRIEF.md
# Translation Lookaside Buffer with Test-Register Port

This block is a 32-entry, 4-way, 8-set translation lookaside buffer. Each entry maps a linear page to a physical page and carries protection and attribute bits. The block has no pipeline interface. It is reached only through two 32-bit test registers.

The data register is loaded first. It holds the physical page number, the attribute bits and the target way. A write to the command register then starts the operation selected by its bit 0:

- **Entry write (bit 0 = 0):** commits an entry built from the command word and the data register.
- **Lookup (bit 0 = 1):** searches the set named by the low linear-address bits. The outcome is placed in the result register one clock later.

Each set keeps 3 tree pseudo-LRU bits. A lookup hit moves these bits away from the hit way. The result register reports the bits as they were before that move.

Top module: `tlb_test_port`

## Requirements
- R1: After reset, result_o reads 0, every entry is invalid so any lookup misses, and all LRU bits are 0.
- R2: Entry write. A data_we_i write loads the physical page number (data_i[31:12]), the attribute bits (data_i[11:10]) and the target way (data_i[3:2]). A cmd_we_i write with cmd_i[0]=0 then stores a valid entry at that way. The set is cmd_i[14:12], the tag is cmd_i[31:15] and the protection bits are cmd_i[11:5]. result_o is not changed.
- R3: Lookup. A cmd_we_i write with cmd_i[0]=1 hits only if the entry in set cmd_i[14:12] is valid and its tag equals cmd_i[31:15]. result_o shows the outcome on the clock edge that accepts the command.
- R4: On a hit, result_o holds:
  - [31:12] the physical page number;
  - [11:10] the attribute bits;
  - [9:7] the set's LRU bits as they were before this lookup;
  - [4] = 1;
  - [3:2] the hit way;
  - [6:5] and [1:0] = 0.
- R5: On a miss, result_o is all zero.
- R6: If any of the seven protection bits cmd_i[11:5] differs from the stored bits, the lookup misses.
- R7: The LRU bits use this encoding:
  - Bit 0 = 0 means ways 0/1 are the older pair.
  - Bit 1 = 1 means way 1 is older than way 0.
  - Bit 2 = 1 means way 3 is older than way 2.

  A lookup hit on way w sets bit 0 to (w<2). It also sets bit 1 (if w<2) or bit 2 (if w≥2) to (w even). Misses and entry writes leave the LRU bits unchanged.
- R8: Sets are independent. An entry written to one set is never hit by a lookup in another set.
- R9: If more than one way of a set matches, the lowest-numbered way is reported, and it is that way's LRU position that is updated.
- R10: result_o keeps its value until the next lookup. Data-register writes do not change it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| data_we_i | input | 1 | Data register write strobe |
| data_i | input | 32 | Data register write value |
| cmd_we_i | input | 1 | Command register write strobe; starts the operation |
| cmd_i | input | 32 | Command word: linear page, protection bits, operation bit |
| result_o | output | 32 | Result register |

## Verification
The assertions assume these things about the inputs:
- cmd_i is meaningful only in a cycle where cmd_we_i is high.
- A lookup's result is read no earlier than the edge after the command.
- The data register is settled before a write command uses it.

The driver keeps to this by raising each strobe for exactly one cycle. It loads the data register in a cycle of its own before each entry write. The monitor compares result_o only at the falling edge after an accepted lookup. Random traffic draws from a few tags and two protection patterns, so that hits, protection misses and repeated hits on the same set's LRU bits all occur often.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int LIN_W  = 20;
  localparam int SET_W  = 3;
  localparam int NSETS  = 1 << SET_W;
  localparam int TAG_W  = LIN_W - SET_W;
  localparam int PROT_W = 7;
  localparam int PPN_W  = 20;
  localparam int ATTR_W = 2;
  localparam int NWAYS  = 4;
  localparam int WAY_W  = $clog2(NWAYS);
  localparam int LRU_W  = NWAYS - 1;
  localparam int WORD_W = 32;

  typedef struct packed {
    logic              vld;
    logic [TAG_W-1:0]  tag;
    logic [PROT_W-1:0] prot;
    logic [PPN_W-1:0]  ppn;
    logic [ATTR_W-1:0] attr;
  } tlb_entry_t;

  // tree pseudo-LRU: point away from the touched way
  function automatic logic [LRU_W-1:0] plru_touch(input logic [LRU_W-1:0] cur,
                                                  input logic [WAY_W-1:0] way);
    logic [LRU_W-1:0] nxt;
    nxt = cur;
    if (!way[1]) begin
      nxt[0] = 1'b1;
      nxt[1] = ~way[0];
    end else begin
      nxt[0] = 1'b0;
      nxt[2] = ~way[0];
    end
    return nxt;
  endfunction
endpackage

// File: rtl/tlb_way.sv
module tlb_way
  import tlb_pkg::*;
#(
  parameter int SetW  = SET_W,
  localparam int Sets = 1 << SetW
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  logic [SetW-1:0] wr_set_i,
  input  tlb_entry_t      wr_entry_i,
  input  logic [SetW-1:0] rd_set_i,
  output tlb_entry_t      rd_entry_o
);
  tlb_entry_t mem_q [Sets];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < Sets; s++) mem_q[s] <= '0;
    end else if (we_i) begin
      mem_q[wr_set_i] <= wr_entry_i;
    end
  end

  assign rd_entry_o = mem_q[rd_set_i];
endmodule

// File: rtl/tlb_match.sv
module tlb_match
  import tlb_pkg::*;
(
  input  tlb_entry_t [NWAYS-1:0] ent_i,
  input  logic [TAG_W-1:0]       tag_i,
  input  logic [PROT_W-1:0]      prot_i,
  output logic                   hit_o,
  output logic [WAY_W-1:0]       way_o,
  output tlb_entry_t             ent_o
);
  logic [NWAYS-1:0] way_hit;

  for (genvar w = 0; w < NWAYS; w++) begin : g_cmp
    assign way_hit[w] = ent_i[w].vld && (ent_i[w].tag == tag_i) &&
                        (ent_i[w].prot == prot_i);
  end

  // lowest way wins
  always_comb begin
    hit_o = 1'b0;
    way_o = '0;
    ent_o = '0;
    for (int w = NWAYS - 1; w >= 0; w--) begin
      if (way_hit[w]) begin
        hit_o = 1'b1;
        way_o = WAY_W'(w);
        ent_o = ent_i[w];
      end
    end
  end
endmodule

// File: rtl/tlb_plru.sv
module tlb_plru
  import tlb_pkg::*;
#(
  parameter int SetW  = SET_W,
  localparam int Sets = 1 << SetW
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SetW-1:0]  set_i,
  input  logic             upd_i,
  input  logic [WAY_W-1:0] way_i,
  output logic [LRU_W-1:0] lru_o
);
  logic [LRU_W-1:0] lru_q [Sets];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < Sets; s++) lru_q[s] <= '0;
    end else if (upd_i) begin
      lru_q[set_i] <= plru_touch(lru_q[set_i], way_i);
    end
  end

  assign lru_o = lru_q[set_i];
endmodule

// File: rtl/tlb_test_port.sv
module tlb_test_port
  import tlb_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              data_we_i,
  input  logic [WORD_W-1:0] data_i,
  input  logic              cmd_we_i,
  input  logic [WORD_W-1:0] cmd_i,
  output logic [WORD_W-1:0] result_o
);
  logic [PPN_W-1:0]  dr_ppn_q;
  logic [ATTR_W-1:0] dr_attr_q;
  logic [WAY_W-1:0]  dr_way_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dr_ppn_q  <= '0;
      dr_attr_q <= '0;
      dr_way_q  <= '0;
    end else if (data_we_i) begin
      dr_ppn_q  <= data_i[31:12];
      dr_attr_q <= data_i[11:10];
      dr_way_q  <= data_i[3:2];
    end
  end

  // command decode
  logic [LIN_W-1:0]  lin;
  logic [SET_W-1:0]  set_idx;
  logic [TAG_W-1:0]  tag;
  logic [PROT_W-1:0] prot;
  logic              do_wr, do_lk;

  assign lin     = cmd_i[31:12];
  assign set_idx = lin[SET_W-1:0];
  assign tag     = lin[LIN_W-1:SET_W];
  assign prot    = cmd_i[11:5];
  assign do_wr   = cmd_we_i && !cmd_i[0];
  assign do_lk   = cmd_we_i && cmd_i[0];

  tlb_entry_t              wr_entry;
  tlb_entry_t [NWAYS-1:0]  rd_ent;

  assign wr_entry = '{vld: 1'b1, tag: tag, prot: prot, ppn: dr_ppn_q, attr: dr_attr_q};

  for (genvar w = 0; w < NWAYS; w++) begin : g_way
    tlb_way #(.SetW(SET_W)) u_way (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .we_i       (do_wr && (dr_way_q == WAY_W'(w))),
      .wr_set_i   (set_idx),
      .wr_entry_i (wr_entry),
      .rd_set_i   (set_idx),
      .rd_entry_o (rd_ent[w])
    );
  end

  logic             hit;
  logic [WAY_W-1:0] hit_way;
  tlb_entry_t       hit_ent;
  logic [LRU_W-1:0] lru_cur;

  tlb_match u_match (
    .ent_i  (rd_ent),
    .tag_i  (tag),
    .prot_i (prot),
    .hit_o  (hit),
    .way_o  (hit_way),
    .ent_o  (hit_ent)
  );

  tlb_plru #(.SetW(SET_W)) u_plru (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (set_idx),
    .upd_i  (do_lk && hit),
    .way_i  (hit_way),
    .lru_o  (lru_cur)
  );

  logic [WORD_W-1:0] result_d, result_q;

  assign result_d = hit ? {hit_ent.ppn, hit_ent.attr, lru_cur, 2'b00, 1'b1, hit_way, 2'b00}
                        : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    result_q <= '0;
    else if (do_lk) result_q <= result_d;
  end

  assign result_o = result_q;
endmodule

// File: rtl/tlb_test_port_chk.sv
module tlb_test_port_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        data_we_i,
  input logic [31:0] data_i,
  input logic        cmd_we_i,
  input logic [31:0] cmd_i,
  input logic [31:0] result_o
);
  p_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cmd_we_i && cmd_i[0]) |=> $stable(result_o));

  p_write_quiet_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_we_i && !cmd_i[0]) |=> $stable(result_o));

  p_miss_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !result_o[4] |-> (result_o == 32'h0));

  p_spare_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    result_o[4] |-> (result_o[6:5] == 2'b00 && result_o[1:0] == 2'b00));

  p_hit_from_lookup_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(result_o[4]) |-> $past(cmd_we_i && cmd_i[0]));

  logic unused_ok;
  assign unused_ok = ^{data_we_i, data_i};
endmodule

bind tlb_test_port tlb_test_port_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .data_we_i (data_we_i),
  .data_i    (data_i),
  .cmd_we_i  (cmd_we_i),
  .cmd_i     (cmd_i),
  .result_o  (result_o)
);

// File: tb/tlb_test_port_tb.sv
`timescale 1ns/1ps
module tlb_test_port_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        data_we = 1'b0;
  logic [31:0] data_w = '0;
  logic        cmd_we = 1'b0;
  logic [31:0] cmd_w = '0;
  logic [31:0] result;

  always #4 clk = ~clk;

  tlb_test_port u_dut (
    .clk_i(clk), .rst_ni(rst_n), .data_we_i(data_we), .data_i(data_w),
    .cmd_we_i(cmd_we), .cmd_i(cmd_w), .result_o(result)
  );

  int n_chk = 0;
  int n_fail = 0;

  // reference model
  logic        m_vld  [8][4];
  logic [16:0] m_tag  [8][4];
  logic [6:0]  m_prot [8][4];
  logic [19:0] m_ppn  [8][4];
  logic [1:0]  m_attr [8][4];
  logic [2:0]  m_lru  [8];
  logic [1:0]  m_dway;
  logic [19:0] m_dppn;
  logic [1:0]  m_dattr;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: result 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic set_data(logic [19:0] ppn, logic [1:0] attr, logic [1:0] way);
    @(negedge clk);
    data_we = 1'b1;
    data_w  = {ppn, attr, 6'b0, way, 2'b0};
    @(negedge clk);
    data_we = 1'b0;
    m_dppn = ppn; m_dattr = attr; m_dway = way;
  endtask

  task automatic write_entry(logic [19:0] lin, logic [6:0] prot, logic [19:0] ppn,
                             logic [1:0] attr, logic [1:0] way);
    logic [31:0] prev;
    set_data(ppn, attr, way);
    check("R10", result, exp_last());
    prev = result;
    @(negedge clk);
    cmd_we = 1'b1;
    cmd_w  = {lin, prot, 4'b0, 1'b0};
    @(negedge clk);
    cmd_we = 1'b0;
    check("R2", result, prev);
    m_vld[lin[2:0]][way]  = 1'b1;
    m_tag[lin[2:0]][way]  = lin[19:3];
    m_prot[lin[2:0]][way] = prot;
    m_ppn[lin[2:0]][way]  = m_dppn;
    m_attr[lin[2:0]][way] = m_dattr;
  endtask

  logic [31:0] last_exp = '0;
  function automatic logic [31:0] exp_last();
    return last_exp;
  endfunction

  task automatic lookup(logic [19:0] lin, logic [6:0] prot, string req);
    logic [2:0]  s;
    logic [31:0] e;
    logic [2:0]  l;
    s = lin[2:0];
    e = '0;
    for (int w = 3; w >= 0; w--) begin
      if (m_vld[s][w] && m_tag[s][w] == lin[19:3] && m_prot[s][w] == prot)
        e = {m_ppn[s][w], m_attr[s][w], m_lru[s], 2'b00, 1'b1, 2'(w), 2'b00};
    end
    if (e[4]) begin
      l = m_lru[s];
      if (!e[3]) begin l[0] = 1'b1; l[1] = ~e[2]; end
      else       begin l[0] = 1'b0; l[2] = ~e[2]; end
      m_lru[s] = l;
    end
    exp_q.push_back(e);
    tag_q.push_back(req);
    last_exp = e;
    @(negedge clk);
    cmd_we = 1'b1;
    cmd_w  = {lin, prot, 4'b0, 1'b1};
    @(negedge clk);
    cmd_we = 1'b0;
  endtask

  // monitor
  logic pend = 1'b0;
  always @(posedge clk) pend <= rst_n && cmd_we && cmd_w[0];
  always @(negedge clk) begin
    if (pend) begin
      if (exp_q.size() == 0) begin
        n_chk++; n_fail++;
        $display("FAIL R3: unexpected result 0x%08h expected none", result);
      end else begin
        check(tag_q.pop_front(), result, exp_q.pop_front());
      end
    end
  end

  initial begin
    repeat (60000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: timeout 1 expected 0");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int s = 0; s < 8; s++) begin
      m_lru[s] = '0;
      for (int w = 0; w < 4; w++) begin
        m_vld[s][w] = 1'b0; m_tag[s][w] = '0; m_prot[s][w] = '0;
        m_ppn[s][w] = '0;   m_attr[s][w] = '0;
      end
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", result, 32'h0);
    lookup({17'h00001, 3'd3}, 7'h00, "R1");
    lookup({17'h00000, 3'd0}, 7'h00, "R5");

    // fill set 3, walk LRU
    for (int w = 0; w < 4; w++)
      write_entry({17'h100 + 17'(w), 3'd3}, 7'h2A, 20'hA0000 + 20'(w), 2'(w), 2'(w));
    lookup({17'h100, 3'd3}, 7'h2A, "R4");
    lookup({17'h102, 3'd3}, 7'h2A, "R7");
    lookup({17'h103, 3'd3}, 7'h2A, "R7");
    lookup({17'h101, 3'd3}, 7'h2A, "R7");
    lookup({17'h101, 3'd3}, 7'h2B, "R6");
    lookup({17'h100, 3'd3}, 7'h6A, "R6");
    lookup({17'h102, 3'd3}, 7'h2A, "R7");
    lookup({17'h102, 3'd3}, 7'h2A, "R4");

    // set isolation
    lookup({17'h100, 3'd4}, 7'h2A, "R8");
    write_entry({17'h100, 3'd4}, 7'h2A, 20'h55555, 2'd3, 2'd2);
    lookup({17'h100, 3'd4}, 7'h2A, "R8");
    lookup({17'h100, 3'd3}, 7'h2A, "R8");

    // duplicate tag in ways 1 and 3 of set 6
    write_entry({17'h777, 3'd6}, 7'h11, 20'h33333, 2'd1, 2'd3);
    write_entry({17'h777, 3'd6}, 7'h11, 20'h11111, 2'd2, 2'd1);
    lookup({17'h777, 3'd6}, 7'h11, "R9");
    lookup({17'h777, 3'd6}, 7'h11, "R9");

    // overwrite and hold
    write_entry({17'h777, 3'd6}, 7'h11, 20'h22222, 2'd0, 2'd1);
    lookup({17'h777, 3'd6}, 7'h11, "R2");
    set_data(20'hFFFFF, 2'd3, 2'd0);
    check("R10", result, last_exp);
    repeat (5) @(negedge clk);
    check("R10", result, last_exp);

    // random traffic
    for (int i = 0; i < 400; i++) begin
      logic [19:0] lin;
      logic [6:0]  pr;
      lin = {17'h40 + 17'($urandom % 4), 3'($urandom % 8)};
      pr  = ($urandom % 2) ? 7'h55 : 7'h0F;
      if ($urandom % 3 == 0)
        write_entry(lin, pr, 20'($urandom), 2'($urandom), 2'($urandom));
      else
        lookup(lin, pr, "R3");
    end

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      n_chk++; n_fail++;
      $display("FAIL R3: %0d results missing expected 0", exp_q.size());
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule